// File: doc/BRIEF.md
# Capture-Compare Timer with Delayed One-Shot Output

This block is a free-running up-counter paired with one capture register and two compare registers. A rising edge on the external trigger pin stores the current count and raises a capture event. Firmware handles that event. It loads the first compare register with the captured count plus a delay, and the second with that value plus a pulse width. It then arms the output flip-flop. When armed, the flip-flop inverts on each compare match. A match on the second register disarms it, so each trigger yields exactly one pulse of the programmed width after the programmed delay. The counter is never cleared, so other users of the same time base keep running undisturbed.

A prescaler sets the counting rate. It can advance the counter on every system clock, on every eighth clock, or on every thirty-second clock. This lets millisecond-scale delays fit in the counter width. A small register port gives firmware its controls: run, rate, interrupt enables, compare values, arming and a forced clear of the output. The same port returns the capture value, the live count and three sticky event flags. The three interrupt outputs are one-clock pulses.

Top module: `ccp_oneshot_timer`

## Requirements
- R1: After reset the count, capture value, status flags, arming bit, output pin and interrupt outputs are all 0, and the counter is stopped.
- R2: The counter advances by exactly one on each prescaler tick while the run bit (control bit 0) is 1, and holds its value while run is 0. Rate code control[2:1] selects the divide ratio: 0 gives 1, 1 gives 8, and 2 or 3 give 32. With ratio N, the count reads k/N (rounded down) higher k clocks after run is written to 1.
- R3: The count wraps from all ones to zero and is never cleared by a compare match. Compare values that wrap past zero still time the pulse correctly.
- R4: A trigger rising edge is synchronized through two flops. While running, the capture register then holds the count that was visible two clocks after the first clock edge that samples the trigger high. Status bit 0 is set, and irq_cap_o pulses for one clock if control bit 3 is 1.
- R5: A compare match happens in the clock after the counter steps onto a compare value. Register A sets status bit 1 and register B sets status bit 2. They pulse irq_cmpa_o and irq_cmpb_o for one clock when control bits 4 and 5, respectively, are 1.
- R6: While armed, the output inverts one clock after each match. The output stays high for (B − A mod 2^16) × ratio clocks. At the rising clock the count reads A+1 for ratio 1 and A otherwise.
- R7: A match on register B while armed clears the arming bit (output-control read bit 0), so no further pulse follows.
- R8: While disarmed, compare matches leave the output unchanged but still set their status flags.
- R9: When A equals B, the coincident matches invert the output once, set both status bits 1 and 2, and disarm.
- R10: Writing the status register clears each flag written with 1. Flags written with 0 are kept.
- R11: Writing output-control bit 1 as 1 forces the output to 0. Output-control bit 0 written sets the arming bit; a read returns the arming bit in bit 0 and the output level in bit 1.
- R12: With an interrupt enable at 0, the matching event still sets its status flag but leaves its interrupt output low.
- R13: Register addresses: 0 control, 1 compare A, 2 compare B, 3 output control, 4 capture (read-only), 5 count (read-only), 6 status, 7 reads zero. Reads are combinational from addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for addr_i |
| trig_i | input | 1 | Asynchronous external trigger |
| pulse_o | output | 1 | Output flip-flop level |
| irq_cap_o | output | 1 | Capture interrupt pulse |
| irq_cmpa_o | output | 1 | Compare A interrupt pulse |
| irq_cmpb_o | output | 1 | Compare B interrupt pulse |

## Verification
The critical coincidence is both compare registers matching in the same clock. The design must invert the output once instead of twice, raise both flags and still disarm. The bench provokes this by loading A and B with the same future count while armed. It then expects the output high, both status bits set and the arming bit cleared. A second coincidence is a status flag set by an event in the same clock as a write-one-clear. Setting must win. The assertion on match-to-flag timing covers this, while the bench checks clearing flags selectively at the ports. Pulse widths are swept over several delays, widths and all three rates, and over a counter wrap. Each width is compared with the arithmetic product of width and ratio.

// File: rtl/ccpt_pkg.sv
package ccpt_pkg;

   localparam int unsigned ADDR_W = 3;
   localparam int unsigned CTRL_W = 6;
   localparam int unsigned EVT_W  = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL  = 3'd0,
      RA_CMPA  = 3'd1,
      RA_CMPB  = 3'd2,
      RA_OUTC  = 3'd3,
      RA_CAPT  = 3'd4,
      RA_COUNT = 3'd5,
      RA_STAT  = 3'd6,
      RA_NONE  = 3'd7
   } reg_addr_e;

   typedef enum logic [1:0] {
      SEL_D1  = 2'd0,
      SEL_DM  = 2'd1,
      SEL_DX  = 2'd2,
      SEL_DX2 = 2'd3
   } div_sel_e;

   // bit 0 run, bits 2:1 rate, bit 3 capture ie, bit 4 cmp A ie, bit 5 cmp B ie
   typedef struct packed {
      logic     ie_b;
      logic     ie_a;
      logic     ie_cap;
      div_sel_e rate;
      logic     run;
   } ctrl_t;

   // status / event vector positions
   localparam int unsigned EV_CAP = 0;
   localparam int unsigned EV_A   = 1;
   localparam int unsigned EV_B   = 2;

endpackage

// File: rtl/ccpt_prescale.sv
module ccpt_prescale #(
   parameter int unsigned DIV_MID = 8,
   parameter int unsigned DIV_MAX = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               run_i,
   input  ccpt_pkg::div_sel_e sel_i,
   output logic               tick_o
);
   import ccpt_pkg::*;

   localparam int unsigned PW = $clog2(DIV_MAX);
   localparam logic [PW-1:0] LIM_MID = PW'(DIV_MID - 1);
   localparam logic [PW-1:0] LIM_MAX = PW'(DIV_MAX - 1);

   generate
      if (DIV_MID < 2 || DIV_MAX <= DIV_MID) begin : g_bad_ratio
         $error("ccpt_prescale: need 2 <= DIV_MID < DIV_MAX");
      end
   endgenerate

   logic [PW-1:0] pre_q;
   logic [PW-1:0] lim;
   logic          lap;

   always_comb begin
      case (sel_i)
         SEL_D1:  lim = '0;
         SEL_DM:  lim = LIM_MID;
         default: lim = LIM_MAX;
      endcase
   end

   assign lap    = (pre_q >= lim);
   assign tick_o = run_i & lap;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_q <= '0;
      end else if (!run_i || lap) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

endmodule

// File: rtl/ccpt_edge_sync.sv
module ccpt_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ccpt_edge_sync: at least two stages required");
      end
   endgenerate

   // sh_q[STAGES] holds the previous synchronized level
   logic [STAGES:0] sh_q;

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sh_q[i] <= 1'b0;
            else         sh_q[i] <= async_i;
         end
      end else begin : g_tail
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sh_q[i] <= 1'b0;
            else         sh_q[i] <= sh_q[i-1];
         end
      end
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/ccpt_core.sv
module ccpt_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             rise_i,
   input  logic [CNT_W-1:0] cmpa_i,
   input  logic [CNT_W-1:0] cmpb_i,
   input  logic             ie_cap_i,
   input  logic             ie_a_i,
   input  logic             ie_b_i,
   input  logic             oc_we_i,
   input  logic             oc_arm_i,
   input  logic             oc_clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cap_o,
   output logic             arm_o,
   output logic             pulse_o,
   output logic             cap_evt_o,
   output logic             match_a_o,
   output logic             match_b_o,
   output logic             irq_cap_o,
   output logic             irq_a_o,
   output logic             irq_b_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cap_q;
   logic             adv_q;
   logic             arm_q;
   logic             out_q;
   logic             irq_cap_q;
   logic             irq_a_q;
   logic             irq_b_q;
   logic             hit_any;

   // counter: free running, wraps naturally, never cleared by matches
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         adv_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(tick_i);
         adv_q <= tick_i;
      end
   end

   // a match is reported once, in the clock after the step onto the value
   assign match_a_o = adv_q & (cnt_q == cmpa_i);
   assign match_b_o = adv_q & (cnt_q == cmpb_i);
   assign cap_evt_o = rise_i & run_i;
   assign hit_any   = match_a_o | match_b_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cap_q <= '0;
      end else if (cap_evt_o) begin
         cap_q <= cnt_q;
      end
   end

   // arming: the B match disarms and wins over a coincident write
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         arm_q <= 1'b0;
      end else if (arm_q && match_b_o) begin
         arm_q <= 1'b0;
      end else if (oc_we_i) begin
         arm_q <= oc_arm_i;
      end
   end

   // output flop: forced clear has priority over a toggle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_q <= 1'b0;
      end else if (oc_we_i && oc_clr_i) begin
         out_q <= 1'b0;
      end else if (arm_q && hit_any) begin
         out_q <= ~out_q;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_cap_q <= 1'b0;
         irq_a_q   <= 1'b0;
         irq_b_q   <= 1'b0;
      end else begin
         irq_cap_q <= cap_evt_o & ie_cap_i;
         irq_a_q   <= match_a_o & ie_a_i;
         irq_b_q   <= match_b_o & ie_b_i;
      end
   end

   assign cnt_o     = cnt_q;
   assign cap_o     = cap_q;
   assign arm_o     = arm_q;
   assign pulse_o   = out_q;
   assign irq_cap_o = irq_cap_q;
   assign irq_a_o   = irq_a_q;
   assign irq_b_o   = irq_b_q;

endmodule

// File: rtl/ccpt_regs.sv
module ccpt_regs #(
   parameter int unsigned CNT_W = 16
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          wr_en_i,
   input  logic [ccpt_pkg::ADDR_W-1:0]   addr_i,
   input  logic [CNT_W-1:0]              wdata_i,
   output logic [CNT_W-1:0]              rdata_o,
   input  logic [CNT_W-1:0]              cnt_i,
   input  logic [CNT_W-1:0]              cap_i,
   input  logic                          arm_i,
   input  logic                          pulse_i,
   input  logic [ccpt_pkg::EVT_W-1:0]    evt_i,
   output ccpt_pkg::ctrl_t               ctrl_o,
   output logic [CNT_W-1:0]              cmpa_o,
   output logic [CNT_W-1:0]              cmpb_o,
   output logic                          oc_we_o,
   output logic                          oc_arm_o,
   output logic                          oc_clr_o,
   output logic [ccpt_pkg::EVT_W-1:0]    stat_o
);
   import ccpt_pkg::*;

   generate
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("ccpt_regs: CNT_W must hold the control fields");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] cmpa_q;
   logic [CNT_W-1:0] cmpb_q;
   logic [EVT_W-1:0] stat_q;
   logic [EVT_W-1:0] w1c;
   reg_addr_e        sel;

   assign sel = reg_addr_e'(addr_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         cmpa_q <= '0;
         cmpb_q <= '0;
      end else if (wr_en_i) begin
         case (sel)
            RA_CTRL: ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
            RA_CMPA: cmpa_q <= wdata_i;
            RA_CMPB: cmpb_q <= wdata_i;
            default: ;
         endcase
      end
   end

   assign w1c = (wr_en_i && sel == RA_STAT) ? wdata_i[EVT_W-1:0] : '0;

   // an event in the same clock as a clear keeps the flag set
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q <= '0;
      else         stat_q <= (stat_q & ~w1c) | evt_i;
   end

   always_comb begin
      case (sel)
         RA_CTRL:  rdata_o = CNT_W'(ctrl_q);
         RA_CMPA:  rdata_o = cmpa_q;
         RA_CMPB:  rdata_o = cmpb_q;
         RA_OUTC:  rdata_o = CNT_W'({pulse_i, arm_i});
         RA_CAPT:  rdata_o = cap_i;
         RA_COUNT: rdata_o = cnt_i;
         RA_STAT:  rdata_o = CNT_W'(stat_q);
         default:  rdata_o = '0;
      endcase
   end

   assign oc_we_o  = wr_en_i && (sel == RA_OUTC);
   assign oc_arm_o = wdata_i[0];
   assign oc_clr_o = wdata_i[1];
   assign ctrl_o   = ctrl_q;
   assign cmpa_o   = cmpa_q;
   assign cmpb_o   = cmpb_q;
   assign stat_o   = stat_q;

endmodule

// File: rtl/ccp_oneshot_timer.sv
module ccp_oneshot_timer #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned DIV_MID     = 8,
   parameter int unsigned DIV_MAX     = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [2:0]       addr_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] rdata_o,
   input  logic             trig_i,
   output logic             pulse_o,
   output logic             irq_cap_o,
   output logic             irq_cmpa_o,
   output logic             irq_cmpb_o
);
   import ccpt_pkg::*;

   ctrl_t            ctrl_w;
   logic             tick_w;
   logic             rise_w;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] cap_w;
   logic [CNT_W-1:0] cmpa_w;
   logic [CNT_W-1:0] cmpb_w;
   logic             arm_w;
   logic             cap_evt_w;
   logic             match_a_w;
   logic             match_b_w;
   logic             oc_we_w;
   logic             oc_arm_w;
   logic             oc_clr_w;
   logic [EVT_W-1:0] evt_w;
   logic [EVT_W-1:0] stat_w;

   assign evt_w = {match_b_w, match_a_w, cap_evt_w};

   ccpt_prescale #(
      .DIV_MID (DIV_MID),
      .DIV_MAX (DIV_MAX)
   ) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (ctrl_w.run),
      .sel_i  (ctrl_w.rate),
      .tick_o (tick_w)
   );

   ccpt_edge_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (trig_i),
      .rise_o  (rise_w)
   );

   ccpt_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_w),
      .run_i     (ctrl_w.run),
      .rise_i    (rise_w),
      .cmpa_i    (cmpa_w),
      .cmpb_i    (cmpb_w),
      .ie_cap_i  (ctrl_w.ie_cap),
      .ie_a_i    (ctrl_w.ie_a),
      .ie_b_i    (ctrl_w.ie_b),
      .oc_we_i   (oc_we_w),
      .oc_arm_i  (oc_arm_w),
      .oc_clr_i  (oc_clr_w),
      .cnt_o     (cnt_w),
      .cap_o     (cap_w),
      .arm_o     (arm_w),
      .pulse_o   (pulse_o),
      .cap_evt_o (cap_evt_w),
      .match_a_o (match_a_w),
      .match_b_o (match_b_w),
      .irq_cap_o (irq_cap_o),
      .irq_a_o   (irq_cmpa_o),
      .irq_b_o   (irq_cmpb_o)
   );

   ccpt_regs #(
      .CNT_W (CNT_W)
   ) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .addr_i   (addr_i),
      .wdata_i  (wdata_i),
      .rdata_o  (rdata_o),
      .cnt_i    (cnt_w),
      .cap_i    (cap_w),
      .arm_i    (arm_w),
      .pulse_i  (pulse_o),
      .evt_i    (evt_w),
      .ctrl_o   (ctrl_w),
      .cmpa_o   (cmpa_w),
      .cmpb_o   (cmpb_w),
      .oc_we_o  (oc_we_w),
      .oc_arm_o (oc_arm_w),
      .oc_clr_o (oc_clr_w),
      .stat_o   (stat_w)
   );

endmodule

// File: rtl/ccp_oneshot_timer_chk.sv
module ccp_oneshot_timer_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             run_i,
   input logic [CNT_W-1:0] cnt_i,
   input logic [CNT_W-1:0] cap_i,
   input logic             cap_evt_i,
   input logic             match_a_i,
   input logic             match_b_i,
   input logic             arm_i,
   input logic             pulse_i,
   input logic             force_i,
   input logic [2:0]       stat_i,
   input logic             irq_cap_i
);

   a_r1_reset_idle: assert property (@(posedge clk_i)
      !rst_ni |=> (!pulse_i && !arm_i && cnt_i == '0 && stat_i == 3'b000));

   a_r2_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> cnt_i == $past(cnt_i));

   a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |=> (cnt_i == $past(cnt_i)) || (cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

   a_r4_capture_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_evt_i |=> cap_i == $past(cnt_i));

   a_r4_irq_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_cap_i |=> !irq_cap_i);

   a_r5_flag_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_a_i |=> stat_i[1]);

   a_r5_flag_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_b_i |=> stat_i[2]);

   a_r6_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arm_i && (match_a_i || match_b_i) && !force_i) |=> pulse_i != $past(pulse_i));

   a_r7_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arm_i && match_b_i) |=> !arm_i);

   a_r8_hold_disarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!arm_i && !force_i) |=> $stable(pulse_i));

   a_r11_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_i |=> !pulse_i);

endmodule

bind ccp_oneshot_timer ccp_oneshot_timer_chk #(
   .CNT_W (CNT_W)
) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .run_i     (ctrl_w.run),
   .cnt_i     (cnt_w),
   .cap_i     (cap_w),
   .cap_evt_i (cap_evt_w),
   .match_a_i (match_a_w),
   .match_b_i (match_b_w),
   .arm_i     (arm_w),
   .pulse_i   (pulse_o),
   .force_i   (oc_we_w & oc_clr_w),
   .stat_i    (stat_w),
   .irq_cap_i (irq_cap_o)
);

// File: tb/ccp_oneshot_timer_tb_top.sv
module ccp_oneshot_timer_tb_top;

   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    addr = 3'd0;
   logic [CW-1:0] wdata = '0;
   logic [CW-1:0] rdata;
   logic          trig = 1'b0;
   logic          pulse;
   logic          irqc;
   logic          irqa;
   logic          irqb;

   int n_chk = 0;
   int n_bad = 0;
   int n_irqc = 0;
   int n_irqa = 0;
   int n_irqb = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ccp_oneshot_timer dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .wr_en_i    (wr_en),
      .addr_i     (addr),
      .wdata_i    (wdata),
      .rdata_o    (rdata),
      .trig_i     (trig),
      .pulse_o    (pulse),
      .irq_cap_o  (irqc),
      .irq_cmpa_o (irqa),
      .irq_cmpb_o (irqb)
   );

   always @(negedge clk) begin
      if (irqc) n_irqc++;
      if (irqa) n_irqa++;
      if (irqb) n_irqb++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [CW-1:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   function automatic logic [CW-1:0] ctl(input bit run, input int sel, input bit ie);
      return CW'({ie, ie, ie, 2'(sel), run});
   endfunction

   function automatic int ratio(input int sel);
      return (sel == 0) ? 1 : (sel == 1) ? 8 : 32;
   endfunction

   task automatic one_shot(input int sel, input int d, input int p, input bit ie);
      logic [CW-1:0] c0, cap, v;
      int ic, ia, ib, w, guard;
      ic = n_irqc; ia = n_irqa; ib = n_irqb;
      trig = 1'b1;
      rd(3'd5, c0);
      guard = 0;
      do begin
         @(negedge clk);
         rd(3'd6, v);
         guard++;
      end while (!v[0] && guard < 50);
      check(v[0], "R4 capture flag", int'(v), 1);
      trig = 1'b0;
      rd(3'd4, cap);
      if (sel == 0) check(cap == CW'(c0 + 2), "R4 capture value", int'(cap), int'(CW'(c0 + 2)));
      wr(3'd1, CW'(cap + d));
      wr(3'd2, CW'(cap + d + p));
      wr(3'd3, 16'd1);
      wr(3'd6, 16'd7);
      guard = 0;
      while (!pulse && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      rd(3'd5, v);
      check(v == CW'(cap + d + ((sel == 0) ? 1 : 0)), "R6 delay count at rise",
            int'(v), int'(CW'(cap + d + ((sel == 0) ? 1 : 0))));
      w = 0;
      while (pulse && w < 5000) begin
         w++;
         @(negedge clk);
      end
      check(w == p * ratio(sel), "R6 pulse width", w, p * ratio(sel));
      rd(3'd3, v);
      check(v[0] == 1'b0, "R7 disarmed after B", int'(v[0]), 0);
      rd(3'd6, v);
      check(v[2:1] == 2'b11, "R5 match flags", int'(v[2:1]), 3);
      repeat (3 * ratio(sel)) @(negedge clk);
      check(pulse == 1'b0, "R7 single pulse", int'(pulse), 0);
      if (ie) begin
         check((n_irqc - ic) == 1 && (n_irqa - ia) == 1 && (n_irqb - ib) == 1,
               "R5 interrupt pulses", (n_irqc - ic) + (n_irqa - ia) + (n_irqb - ib), 3);
      end else begin
         check(n_irqc == ic && n_irqa == ia && n_irqb == ib, "R12 masked interrupts",
               (n_irqc - ic) + (n_irqa - ia) + (n_irqb - ib), 0);
      end
      wr(3'd6, 16'd7);
   endtask

   initial begin
      logic [CW-1:0] v, c0;
      int guard;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(pulse == 1'b0, "R1 output low", int'(pulse), 0);
      check(!irqc && !irqa && !irqb, "R1 irqs low", int'({irqc, irqa, irqb}), 0);
      rd(3'd5, v); check(v == 0, "R1 count zero", int'(v), 0);
      rd(3'd6, v); check(v == 0, "R1 status zero", int'(v), 0);
      rd(3'd3, v); check(v == 0, "R1 disarmed", int'(v), 0);
      rd(3'd0, v); check(v == 0, "R1 stopped", int'(v), 0);
      rd(3'd7, v); check(v == 0, "R13 spare address reads zero", int'(v), 0);
      repeat (10) @(negedge clk);
      rd(3'd5, v); check(v == 0, "R2 no count before run", int'(v), 0);

      // R2 rate sweep
      for (int s = 0; s < 3; s++) begin
         wr(3'd0, ctl(1'b0, s, 1'b1));
         rd(3'd5, c0);
         repeat (17) @(negedge clk);
         rd(3'd5, v);
         check(v == c0, "R2 hold while stopped", int'(v), int'(c0));
         wr(3'd0, ctl(1'b1, s, 1'b1));
         repeat (4 * ratio(s) - 1) @(negedge clk);
         rd(3'd5, v);
         check(v == CW'(c0 + 3), "R2 count before boundary", int'(v), int'(CW'(c0 + 3)));
         @(negedge clk);
         rd(3'd5, v);
         check(v == CW'(c0 + 4), "R2 count at boundary", int'(v), int'(CW'(c0 + 4)));
         rd(3'd0, v);
         check(v[2:1] == 2'(s), "R13 control readback", int'(v[2:1]), s);
         // delay/width sweep at this rate
         for (int di = 0; di < 2; di++) begin
            for (int pi = 0; pi < 3; pi++) begin
               one_shot(s, (di == 0) ? 12 : 29, (pi == 0) ? 1 : (pi == 1) ? 4 : 11, 1'b1);
            end
         end
      end

      // R12 masked interrupts at ratio 1
      wr(3'd0, ctl(1'b0, 0, 1'b0));
      wr(3'd0, ctl(1'b1, 0, 1'b0));
      one_shot(0, 15, 6, 1'b0);
      wr(3'd0, ctl(1'b1, 0, 1'b1));

      // R3 wrap: wait near the top, then time a pulse across zero
      guard = 0;
      do begin
         @(negedge clk);
         rd(3'd5, v);
         guard++;
      end while (v < 16'hFFD0 && guard < 70000);
      one_shot(0, 40, 50, 1'b1);
      rd(3'd5, v);
      check(v < 16'h0200, "R3 counter wrapped, not cleared", int'(v), 0);

      // R8 matches while disarmed
      rd(3'd5, c0);
      wr(3'd3, 16'd0);
      wr(3'd1, CW'(c0 + 20));
      wr(3'd6, 16'd7);
      repeat (40) @(negedge clk);
      check(pulse == 1'b0, "R8 output unchanged when disarmed", int'(pulse), 0);
      rd(3'd6, v);
      check(v[1] == 1'b1, "R8 flag still set", int'(v), 2);

      // R9 coincident A and B
      rd(3'd5, c0);
      wr(3'd1, CW'(c0 + 25));
      wr(3'd2, CW'(c0 + 25));
      wr(3'd3, 16'd1);
      wr(3'd6, 16'd7);
      repeat (40) @(negedge clk);
      check(pulse == 1'b1, "R9 single inversion", int'(pulse), 1);
      rd(3'd6, v);
      check(v[2:0] == 3'b110, "R9 both flags", int'(v[2:0]), 6);
      rd(3'd3, v);
      check(v[1:0] == 2'b10, "R9 disarmed, output high", int'(v[1:0]), 2);

      // R11 forced clear
      wr(3'd3, 16'd2);
      check(pulse == 1'b0, "R11 forced low", int'(pulse), 0);
      rd(3'd3, v);
      check(v[1:0] == 2'b00, "R11 readback", int'(v[1:0]), 0);

      // R10 write-one-clear
      wr(3'd6, 16'd0);
      rd(3'd6, v); check(v[2:0] == 3'b110, "R10 zero write keeps", int'(v[2:0]), 6);
      wr(3'd6, 16'd2);
      rd(3'd6, v); check(v[2:0] == 3'b100, "R10 clear A only", int'(v[2:0]), 4);
      wr(3'd6, 16'd4);
      rd(3'd6, v); check(v[2:0] == 3'b000, "R10 clear B", int'(v[2:0]), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule